// File: doc/BRIEF.md
# Fixed-Point Requantizer

This block takes a signed two's-complement word in one fixed-point format and returns the same quantity re-expressed in another fixed-point format. A format is a word width plus a fraction width: the fraction width counts how many bit positions the binary point lies above the least significant bit. Both formats are elaboration-time parameters. The fraction width may be negative, so the LSB weighs more than one. It may also exceed the word width, so the whole word lies below the binary point.

Conversion first moves the binary point. When the destination keeps more fraction bits, the word is shifted left and zeros fill the new low bits. When it keeps fewer, the surplus low bits are dropped, and this rounds toward minus infinity. The aligned value is then fitted to the destination width. Extra integer room is filled by copying the sign bit. Surplus high bits are either discarded (wrap) or replaced by the nearest extreme code (saturate), as a parameter selects. An overflow output marks every result whose value could not be represented.

The block has no clock and no state. It is meant to sit between arithmetic stages of a datapath, where it trims a product or a sum back to a storage format.

Top module: `fxp_requant`

## Requirements
- R1: With the input read as signed and q = floor(in_code × 2^(OUT_F − IN_F)), out_code equals q whenever q lies in [−2^(OUT_W−1), 2^(OUT_W−1) − 1].
- R2: Either fraction width may be negative or larger than its word width. If the right shift removes every input bit, q is 0 for a non-negative input and −1 for a negative one.
- R3: overflow is 1 exactly when q lies outside the destination range, in both overflow modes.
- R4: With MODE = OVF_WRAP, out_code is the low OUT_W bits of q in two's complement.
- R5: With MODE = OVF_SAT and overflow set, out_code is 0 followed by ones (most positive code) when q > 0, and 1 followed by zeros (most negative code) when q < 0.
- R6: When OUT_F > IN_F, the low OUT_F − IN_F bits of a non-overflowing result are zero. When the destination has more integer bits, the sign is copied into them and overflow never rises.
- R7: Input 6'b010101 in format (6,4), which is 1.3125, gives 4'b0101 in format (4,2), which is 1.25, with no overflow.
- R8: Both outputs follow in_code within the same cycle and hold no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_code | input | IN_W | Raw signed word in the source format |
| out_code | output | OUT_W | Raw signed word in the destination format |
| overflow | output | 1 | High when the floored value does not fit the destination |

## Verification
Every result is due in the cycle its input is applied, because no register lies between in_code and either output. The bench therefore changes the input just after a rising edge and reads both outputs at the next falling edge, half a cycle later. The R8 check reads them even earlier in the same cycle. Each sweep applies one code per cycle, so a reading cannot be confused with the code before or after it.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

    typedef enum logic {
        OVF_WRAP = 1'b0,
        OVF_SAT  = 1'b1
    } ovf_mode_e;

    // Width of the word after the binary point is moved; never below one bit.
    function automatic int aligned_width(input int in_w, input int shift);
        int w;
        w = in_w + shift;
        return (w < 1) ? 1 : w;
    endfunction

    // Mask covering the lowest n bits, saturating at 64.
    function automatic logic [63:0] low_mask(input int n);
        if (n <= 0)  return 64'd0;
        if (n >= 64) return {64{1'b1}};
        return (64'd1 << n) - 64'd1;
    endfunction

endpackage

// File: rtl/fxp_align.sv
module fxp_align #(
    parameter int IN_W  = 6,
    parameter int SHIFT = -2,
    localparam int AW   = fxp_pkg::aligned_width(IN_W, SHIFT)
) (
    input  logic [IN_W-1:0] in_i,
    output logic [AW-1:0]   aligned_o
);

    generate
        if (SHIFT > 0) begin : g_left
            assign aligned_o = {in_i, {SHIFT{1'b0}}};
        end else if (SHIFT == 0) begin : g_same
            assign aligned_o = in_i;
        end else if (-SHIFT >= IN_W) begin : g_all_gone
            // floor of a value with magnitude below one LSB: 0 or -1
            assign aligned_o = in_i[IN_W-1];
            logic unused_body;
            assign unused_body = ^in_i;
        end else begin : g_right
            assign aligned_o = in_i[IN_W-1:-SHIFT];
            logic unused_low;
            assign unused_low = ^in_i[-SHIFT-1:0];
        end
    endgenerate

endmodule

// File: rtl/fxp_fit.sv
module fxp_fit #(
    parameter int AW    = 4,
    parameter int OUT_W = 4
) (
    input  logic [AW-1:0]    aligned_i,
    output logic [OUT_W-1:0] wrap_o,
    output logic             ovf_o
);

    generate
        if (AW <= OUT_W) begin : g_widen
            assign wrap_o = OUT_W'($signed(aligned_i));
            assign ovf_o  = 1'b0;
        end else begin : g_narrow
            localparam int UW = AW - OUT_W + 1;
            logic [UW-1:0] upper;
            assign upper  = aligned_i[AW-1:OUT_W-1];
            assign wrap_o = aligned_i[OUT_W-1:0];
            assign ovf_o  = !((&upper) || !(|upper));
        end
    endgenerate

endmodule

// File: rtl/fxp_clamp.sv
module fxp_clamp #(
    parameter int                OUT_W = 4,
    parameter fxp_pkg::ovf_mode_e MODE = fxp_pkg::OVF_WRAP
) (
    input  logic [OUT_W-1:0] wrap_i,
    input  logic             ovf_i,
    input  logic             neg_i,
    output logic [OUT_W-1:0] out_o
);

    localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    generate
        if (MODE == fxp_pkg::OVF_SAT) begin : g_sat
            always_comb begin
                if (ovf_i) out_o = neg_i ? MIN_CODE : MAX_CODE;
                else       out_o = wrap_i;
            end
        end else begin : g_wrap
            assign out_o = wrap_i;
            logic unused_flags;
            assign unused_flags = ovf_i ^ neg_i;
        end
    endgenerate

endmodule

// File: rtl/fxp_requant.sv
module fxp_requant #(
    parameter int                 IN_W  = 6,
    parameter int                 IN_F  = 4,
    parameter int                 OUT_W = 4,
    parameter int                 OUT_F = 2,
    parameter fxp_pkg::ovf_mode_e MODE  = fxp_pkg::OVF_WRAP
) (
    input  logic [IN_W-1:0]  in_code,
    output logic [OUT_W-1:0] out_code,
    output logic             overflow
);

    localparam int SHIFT = OUT_F - IN_F;
    localparam int AW    = fxp_pkg::aligned_width(IN_W, SHIFT);
    localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] ZERO_LOW = OUT_W'(fxp_pkg::low_mask(SHIFT));

    logic [AW-1:0]    aligned;
    logic [OUT_W-1:0] wrapped;
    logic             fit_ovf;

    fxp_align #(.IN_W(IN_W), .SHIFT(SHIFT)) u_align (
        .in_i      (in_code),
        .aligned_o (aligned)
    );

    fxp_fit #(.AW(AW), .OUT_W(OUT_W)) u_fit (
        .aligned_i (aligned),
        .wrap_o    (wrapped),
        .ovf_o     (fit_ovf)
    );

    fxp_clamp #(.OUT_W(OUT_W), .MODE(MODE)) u_clamp (
        .wrap_i (wrapped),
        .ovf_i  (fit_ovf),
        .neg_i  (aligned[AW-1]),
        .out_o  (out_code)
    );

    assign overflow = fit_ovf;

    always_comb begin
        if (!$isunknown(in_code)) begin
            if (MODE == fxp_pkg::OVF_SAT && overflow) begin
                assert_sat_extreme_R5: assert (out_code == MAX_CODE || out_code == MIN_CODE)
                    else $error("saturated result is not an extreme code");
                assert_sat_sign_R5: assert (out_code[OUT_W-1] == in_code[IN_W-1])
                    else $error("saturated result has the wrong sign");
            end
            if (!overflow) begin
                assert_fit_sign_R3: assert (out_code[OUT_W-1] == in_code[IN_W-1])
                    else $error("non-overflowing result changed sign");
                assert_zero_fill_R6: assert ((out_code & ZERO_LOW) == '0)
                    else $error("new fraction bits are not zero");
            end
        end
    end

endmodule

// File: tb/tb_fxp_requant.sv
module tb_requant_sweep #(
    parameter int                 IW   = 6,
    parameter int                 IFR  = 4,
    parameter int                 OW   = 4,
    parameter int                 OFR  = 2,
    parameter fxp_pkg::ovf_mode_e MODE = fxp_pkg::OVF_WRAP,
    parameter string              TAG  = "R1"
) (
    input  logic clk,
    input  logic go,
    output int   checks,
    output int   fails,
    output logic done
);

    logic [IW-1:0] stim = '0;
    logic [OW-1:0] got;
    logic          got_ovf;

    fxp_requant #(.IN_W(IW), .IN_F(IFR), .OUT_W(OW), .OUT_F(OFR), .MODE(MODE)) dut (
        .in_code  (stim),
        .out_code (got),
        .overflow (got_ovf)
    );

    initial begin
        checks = 0;
        fails  = 0;
        done   = 1'b0;
        wait (go);
        for (int c = 0; c < (1 << IW); c++) begin
            logic signed [IW-1:0] sv;
            longint q, maxv, minv, ev;
            logic [OW-1:0] exp_bits;
            logic exp_ovf;
            @(posedge clk);
            #1 stim = IW'(c);
            @(negedge clk);
            sv   = stim;
            q    = longint'($floor(real'(longint'(sv)) * (2.0 ** (OFR - IFR))));
            maxv = (64'sd1 <<< (OW - 1)) - 1;
            minv = -(64'sd1 <<< (OW - 1));
            exp_ovf = (q > maxv) || (q < minv);
            ev = q;
            if (MODE == fxp_pkg::OVF_SAT) begin
                if (q > maxv) ev = maxv;
                if (q < minv) ev = minv;
            end
            exp_bits = OW'(ev);
            checks++;
            if (got !== exp_bits) begin
                fails++;
                $display("FAIL %s value (%0d,%0d)->(%0d,%0d) in=%h actual=%h expected=%h",
                         TAG, IW, IFR, OW, OFR, stim, got, exp_bits);
            end
            checks++;
            if (got_ovf !== exp_ovf) begin
                fails++;
                $display("FAIL R3 overflow (%0d,%0d)->(%0d,%0d) in=%h actual=%b expected=%b",
                         IW, IFR, OW, OFR, stim, got_ovf, exp_ovf);
            end
        end
        done = 1'b1;
    end

endmodule

module tb_fxp_requant;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [5:0] a_in = '0;
    logic [3:0] a_out;
    logic       a_ovf;

    fxp_requant #(.IN_W(6), .IN_F(4), .OUT_W(4), .OUT_F(2), .MODE(fxp_pkg::OVF_WRAP)) dut (
        .in_code  (a_in),
        .out_code (a_out),
        .overflow (a_ovf)
    );

    int   sc [6];
    int   sf [6];
    logic sd [6];

    tb_requant_sweep #(.IW(6), .IFR(4),  .OW(4), .OFR(2),  .MODE(fxp_pkg::OVF_WRAP), .TAG("R1 R4 R7"))
        s0 (.clk(clk), .go(go), .checks(sc[0]), .fails(sf[0]), .done(sd[0]));
    tb_requant_sweep #(.IW(6), .IFR(9),  .OW(5), .OFR(3),  .MODE(fxp_pkg::OVF_SAT),  .TAG("R1 R2 R5"))
        s1 (.clk(clk), .go(go), .checks(sc[1]), .fails(sf[1]), .done(sd[1]));
    tb_requant_sweep #(.IW(7), .IFR(-4), .OW(8), .OFR(0),  .MODE(fxp_pkg::OVF_WRAP), .TAG("R2 R4 R6"))
        s2 (.clk(clk), .go(go), .checks(sc[2]), .fails(sf[2]), .done(sd[2]));
    tb_requant_sweep #(.IW(5), .IFR(1),  .OW(8), .OFR(3),  .MODE(fxp_pkg::OVF_SAT),  .TAG("R1 R6"))
        s3 (.clk(clk), .go(go), .checks(sc[3]), .fails(sf[3]), .done(sd[3]));
    tb_requant_sweep #(.IW(8), .IFR(2),  .OW(5), .OFR(1),  .MODE(fxp_pkg::OVF_SAT),  .TAG("R1 R5"))
        s4 (.clk(clk), .go(go), .checks(sc[4]), .fails(sf[4]), .done(sd[4]));
    tb_requant_sweep #(.IW(4), .IFR(0),  .OW(3), .OFR(-2), .MODE(fxp_pkg::OVF_WRAP), .TAG("R2 R4"))
        s5 (.clk(clk), .go(go), .checks(sc[5]), .fails(sf[5]), .done(sd[5]));

    task automatic check_a(input logic [3:0] exp_out, input logic exp_ovf, input string req);
        checks++;
        if (a_out !== exp_out || a_ovf !== exp_ovf) begin
            fails++;
            $display("FAIL %s in=%b actual=%b/%b expected=%b/%b",
                     req, a_in, a_out, a_ovf, exp_out, exp_ovf);
        end
    endtask

    initial begin
        int cyc;
        logic all_done;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_a(4'b0000, 1'b0, "R1 reset-state");
        rst_n = 1'b1;

        @(posedge clk); #1 a_in = 6'b010101;
        @(negedge clk);
        check_a(4'b0101, 1'b0, "R7 example cast");

        @(posedge clk); #1 a_in = 6'b100000;
        #1 check_a(4'b1000, 1'b0, "R8 same-cycle most negative");

        @(posedge clk); #1 a_in = 6'b011111;
        #1 check_a(4'b0111, 1'b0, "R8 R1 floor of 1.9375");

        @(posedge clk); #1 a_in = 6'b111111;
        @(negedge clk);
        check_a(4'b1111, 1'b0, "R1 floor of -0.0625");

        go  = 1'b1;
        cyc = 0;
        all_done = 1'b0;
        while (!all_done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
            all_done = 1'b1;
            for (int i = 0; i < 6; i++) if (!sd[i]) all_done = 1'b0;
        end
        if (!all_done) begin
            checks++;
            fails++;
            $display("FAIL watchdog sweeps incomplete actual=%0d cycles expected=done", cyc);
        end
        for (int i = 0; i < 6; i++) begin
            checks += sc[i];
            fails  += sf[i];
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule